// File: doc/BRIEF.md
# Indexed Address Generator with Pair Post-Increment

This block forms the 16-bit memory address for the indexed and offset-indexed load/store operations of an 8-bit processor. The core hands it the number of a register (0 to 7), the two bytes of the register pair that contains it, an 8-bit offset and the kind of access. It returns the effective address one clock later. When the odd member of a pair is named and post-increment is built in, it also returns the pair plus one, together with a one-cycle write-back strobe and the pair index. The register file and the memory transfer itself live outside this block.

A pair is always an even register (the low byte) together with the odd register above it (the high byte). Register 5 or register 4 both select the pair built from 5 (high) and 4 (low). Two parameters pick the variant. One decides whether naming the odd register causes a post-increment. The other decides whether the offset is sign-extended or zero-extended before it is added.

Top module: `idx_agen`

## Requirements
- R1: While reset is active and on the first cycles after it, addr_valid and wb_en are 0 and eff_addr, wb_pair and wb_pair_idx are all 0.
- R2: A request with mode=0 (plain indexed) gives eff_addr = {base_hi, base_lo} and addr_valid=1 on the clock edge after the request.
- R3: A request with mode=1 (offset indexed) and ZERO_EXT=0 gives eff_addr = {base_hi, base_lo} + sign-extended offset, modulo 2^16.
- R4: With ZERO_EXT=1, offset mode uses the offset zero-extended to 16 bits, modulo 2^16.
- R5: With AUTO_INC=1, a request whose reg_sel has bit 0 set pulses wb_en for one cycle, with wb_pair = {base_hi, base_lo} + 1 and wb_pair_idx = reg_sel[2:1].
- R6: A request that names an even register (reg_sel bit 0 clear) never raises wb_en.
- R7: With AUTO_INC=0, wb_en stays 0 for every register number and both modes.
- R8: eff_addr is computed from the pair value before the increment, including on odd-register requests.
- R9: The increment carries from the low byte into the high byte, and 0xFFFF wraps to 0x0000.
- R10: A cycle with req_valid=0 gives addr_valid=0 and wb_en=0 on the following edge, so each request yields exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| reg_sel | input | 3 | Named register number |
| base_lo | input | 8 | Even register of the pair (low byte) |
| base_hi | input | 8 | Odd register of the pair (high byte) |
| ofs | input | 8 | Offset byte |
| mode | input | 1 | 0 = plain indexed, 1 = offset indexed |
| eff_addr | output | 16 | Effective address |
| addr_valid | output | 1 | eff_addr valid for this cycle |
| wb_en | output | 1 | Write-back strobe for the incremented pair |
| wb_pair_idx | output | 2 | Pair index to write back |
| wb_pair | output | 16 | Incremented pair value |

## Verification
Every result is registered once, so eff_addr, addr_valid, the write-back strobe, pair and index all appear one edge after the request edge. Nothing arrives later, and the strobes drop on the edge after that. The bench drives a request on a falling edge and removes it on the next falling edge. It reads every output at that second falling edge, which is half a period after the capturing edge. It then reads the strobes again one falling edge later to confirm that they have cleared. Two copies run side by side on the same stimulus, one with post-increment and sign extension and one with neither, over all eight register numbers, both modes and a set of carry and wrap corner values.

// File: rtl/idx_agen_pkg.sv
package idx_agen_pkg;
  typedef enum logic {
    IDX_PLAIN  = 1'b0,
    IDX_OFFSET = 1'b1
  } idx_mode_e;
endpackage

// File: rtl/idx_pair_dec.sv
module idx_pair_dec #(
  parameter int SEL_W    = 3,
  parameter bit AUTO_INC = 1'b1
) (
  input  logic             valid,
  input  logic [SEL_W-1:0] sel,
  output logic [SEL_W-2:0] pair_idx,
  output logic             inc_req
);
  assign pair_idx = sel[SEL_W-1:1];

  generate
    if (AUTO_INC) begin : g_inc
      assign inc_req = valid & sel[0];
    end else begin : g_noinc
      assign inc_req = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/idx_ofs_ext.sv
module idx_ofs_ext
  import idx_agen_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter bit ZERO_EXT = 1'b0
) (
  input  logic [DATA_W-1:0] ofs,
  input  idx_mode_e         mode,
  output logic [ADDR_W-1:0] addend
);
  localparam int PAD_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] ext;

  generate
    if (ZERO_EXT) begin : g_zx
      assign ext = {{PAD_W{1'b0}}, ofs};
    end else begin : g_sx
      assign ext = {{PAD_W{ofs[DATA_W-1]}}, ofs};
    end
  endgenerate

  always_comb begin
    addend = '0;
    if (mode == IDX_OFFSET) begin
      addend = ext;
    end
  end
endmodule

// File: rtl/idx_sum.sv
module idx_sum #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] addend,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] base_inc
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  assign addr     = base + addend;
  assign base_inc = base + ONE;
endmodule

// File: rtl/idx_agen.sv
module idx_agen
  import idx_agen_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int REG_CNT  = 8,
  parameter bit AUTO_INC = 1'b1,
  parameter bit ZERO_EXT = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [$clog2(REG_CNT)-1:0] reg_sel,
  input  logic [DATA_W-1:0]          base_lo,
  input  logic [DATA_W-1:0]          base_hi,
  input  logic [DATA_W-1:0]          ofs,
  input  logic                       mode,
  output logic [2*DATA_W-1:0]        eff_addr,
  output logic                       addr_valid,
  output logic                       wb_en,
  output logic [$clog2(REG_CNT)-2:0] wb_pair_idx,
  output logic [2*DATA_W-1:0]        wb_pair
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam int SEL_W  = $clog2(REG_CNT);
  localparam int IDX_W  = SEL_W - 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  logic [ADDR_W-1:0] base, addend, sum_addr, sum_inc;
  logic [IDX_W-1:0]  dec_idx;
  logic              dec_inc;
  idx_mode_e         mode_e;

  assign base   = {base_hi, base_lo};
  assign mode_e = idx_mode_e'(mode);

  idx_pair_dec #(.SEL_W(SEL_W), .AUTO_INC(AUTO_INC)) u_dec (
    .valid    (req_valid),
    .sel      (reg_sel),
    .pair_idx (dec_idx),
    .inc_req  (dec_inc)
  );

  idx_ofs_ext #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ZERO_EXT(ZERO_EXT)) u_ext (
    .ofs    (ofs),
    .mode   (mode_e),
    .addend (addend)
  );

  idx_sum #(.ADDR_W(ADDR_W)) u_sum (
    .base     (base),
    .addend   (addend),
    .addr     (sum_addr),
    .base_inc (sum_inc)
  );

  // next-state
  logic              addr_ce, wb_ce;
  logic              nxt_addr_valid, nxt_wb_en;
  logic [ADDR_W-1:0] nxt_eff_addr, nxt_wb_pair;
  logic [IDX_W-1:0]  nxt_wb_idx;

  always_comb begin
    addr_ce        = req_valid;
    wb_ce          = dec_inc;
    nxt_addr_valid = req_valid;
    nxt_wb_en      = dec_inc;
    nxt_eff_addr   = sum_addr;
    nxt_wb_pair    = sum_inc;
    nxt_wb_idx     = dec_idx;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      addr_valid <= 1'b0;
      wb_en      <= 1'b0;
    end else begin
      addr_valid <= nxt_addr_valid;
      wb_en      <= nxt_wb_en;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      eff_addr <= '0;
    end else if (addr_ce) begin
      eff_addr <= nxt_eff_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      wb_pair     <= '0;
      wb_pair_idx <= '0;
    end else if (wb_ce) begin
      wb_pair     <= nxt_wb_pair;
      wb_pair_idx <= nxt_wb_idx;
    end
  end
endmodule

// File: rtl/idx_agen_chk.sv
module idx_agen_chk #(
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 3,
  parameter bit AUTO_INC = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [SEL_W-1:0]    reg_sel,
  input logic [DATA_W-1:0]   base_lo,
  input logic [DATA_W-1:0]   base_hi,
  input logic                mode,
  input logic [2*DATA_W-1:0] eff_addr,
  input logic                addr_valid,
  input logic                wb_en,
  input logic [2*DATA_W-1:0] wb_pair
);
  localparam int ADDR_W = 2 * DATA_W;

  AST_ADDR_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid);  // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!addr_valid && !wb_en));  // R10

  AST_WB_WITH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> addr_valid);  // R5

  AST_EVEN_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !reg_sel[0]) |=> !wb_en);  // R6

  AST_PLAIN_PRE_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mode) |=> (eff_addr == $past({base_hi, base_lo})));  // R8

  AST_WB_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_pair == ADDR_W'($past({base_hi, base_lo}) + ADDR_W'(1))));  // R9

  generate
    if (AUTO_INC) begin : g_inc
      AST_ODD_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && reg_sel[0]) |=> wb_en);  // R5
    end else begin : g_noinc
      AST_NO_AUTOINC: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_en);  // R7
    end
  endgenerate
endmodule

bind idx_agen idx_agen_chk #(
  .DATA_W   (DATA_W),
  .SEL_W    ($clog2(REG_CNT)),
  .AUTO_INC (AUTO_INC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .req_valid  (req_valid),
  .reg_sel    (reg_sel),
  .base_lo    (base_lo),
  .base_hi    (base_hi),
  .mode       (mode),
  .eff_addr   (eff_addr),
  .addr_valid (addr_valid),
  .wb_en      (wb_en),
  .wb_pair    (wb_pair)
);

// File: tb/idx_agen_test.sv
module idx_agen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  base_lo = '0, base_hi = '0, ofs = '0;
  logic        mode = 1'b0;

  logic [15:0] a_addr, a_wbp, b_addr, b_wbp;
  logic        a_av, a_wb, b_av, b_wb;
  logic [1:0]  a_idx, b_idx;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  idx_agen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .reg_sel(reg_sel),
    .base_lo(base_lo), .base_hi(base_hi), .ofs(ofs), .mode(mode),
    .eff_addr(a_addr), .addr_valid(a_av), .wb_en(a_wb),
    .wb_pair_idx(a_idx), .wb_pair(a_wbp)
  );

  idx_agen #(.AUTO_INC(1'b0), .ZERO_EXT(1'b1)) uut_zx (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .reg_sel(reg_sel),
    .base_lo(base_lo), .base_hi(base_hi), .ofs(ofs), .mode(mode),
    .eff_addr(b_addr), .addr_valid(b_av), .wb_en(b_wb),
    .wb_pair_idx(b_idx), .wb_pair(b_wbp)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pick_pair(input int k, input int r);
    case (k)
      0: return 16'h0000;
      1: return 16'h00FF;
      2: return 16'hFFFF;
      3: return 16'h7FFF;
      4: return 16'h8000;
      5: return 16'h12FE;
      default: return 16'(k * 16'h1F3B + r * 16'h0101);
    endcase
  endfunction

  function automatic logic [7:0] pick_ofs(input int k, input int r);
    case (k)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h7F;
      3: return 8'h80;
      4: return 8'hFF;
      5: return 8'hFE;
      default: return 8'(k * 8'h29 + r);
    endcase
  endfunction

  initial begin
    #300000;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: held in reset
    chk("R1 addr_valid", 16'(a_av), 16'h0);
    chk("R1 wb_en", 16'(a_wb), 16'h0);
    chk("R1 eff_addr", a_addr, 16'h0);
    chk("R1 wb_pair", a_wbp, 16'h0);
    chk("R1 wb_pair_idx", 16'(a_idx), 16'h0);
    chk("R1 zx eff_addr", b_addr, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 post-reset addr_valid", 16'(a_av), 16'h0);
    chk("R1 post-reset wb_pair", a_wbp, 16'h0);
    chk("R10 idle wb_en", 16'(a_wb), 16'h0);

    for (int r = 0; r < 8; r++) begin
      for (int m = 0; m < 2; m++) begin
        for (int k = 0; k < 10; k++) begin
          logic [15:0] p, sx, zx, ea, eb;
          logic [7:0]  o;
          p  = pick_pair(k, r);
          o  = pick_ofs((k + r) % 10, r);
          sx = {{8{o[7]}}, o};
          zx = {8'h00, o};
          ea = (m == 1) ? 16'(p + sx) : p;
          eb = (m == 1) ? 16'(p + zx) : p;
          // request on a falling edge, captured by the next rising edge
          req_valid = 1'b1;
          reg_sel   = 3'(r);
          base_hi   = p[15:8];
          base_lo   = p[7:0];
          ofs       = o;
          mode      = 1'(m);
          @(negedge clk);
          req_valid = 1'b0;
          chk("R2 addr_valid", 16'(a_av), 16'h1);
          if (m == 0) chk("R2 R8 plain eff_addr", a_addr, ea);
          else        chk("R3 R8 signed offset eff_addr", a_addr, ea);
          chk("R4 zero-ext eff_addr", b_addr, eb);
          chk("R7 no write-back without auto-inc", 16'(b_wb), 16'h0);
          if (r % 2 == 1) begin
            chk("R5 wb_en on odd register", 16'(a_wb), 16'h1);
            chk("R5 R9 wb_pair increment", a_wbp, 16'(p + 16'h1));
            chk("R5 wb_pair_idx", 16'(a_idx), 16'(r / 2));
          end else begin
            chk("R6 no wb_en on even register", 16'(a_wb), 16'h0);
          end
          @(negedge clk);
          chk("R10 addr_valid single pulse", 16'(a_av), 16'h0);
          chk("R10 wb_en single pulse", 16'(a_wb), 16'h0);
        end
      end
    end

    // R9 wrap and carry, explicit
    req_valid = 1'b1; reg_sel = 3'd7; base_hi = 8'hFF; base_lo = 8'hFF; mode = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 wrap to zero", a_wbp, 16'h0000);
    chk("R8 address before wrap", a_addr, 16'hFFFF);
    req_valid = 1'b1; reg_sel = 3'd1; base_hi = 8'h3C; base_lo = 8'hFF;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 carry into high byte", a_wbp, 16'h3D00);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule